// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Set

This block turns the condition signals of a pair of transmit and receive FIFOs into a single interrupt request. Two kinds of source feed one status register. One-cycle event pulses (receive overrun, transmit underrun) latch and stay set until software clears them. Level conditions (transmit below its watermark, transmit full, receive at its watermark, receive full) are resampled on every clock. The transmit watermark test is a strict less-than against a programmable threshold, so a threshold of one means "transmit FIFO empty". The receive watermark test is a greater-or-equal, so a threshold of one means "receive FIFO not empty".

Software uses a small word-addressed register port. One address sets bits in a shared enable mask and another address clears them. A third address reads the mask back. The status register is cleared by writing ones. The two watermark thresholds are ordinary read/write registers. The interrupt line is raised while any status bit is set whose mask bit is also set.

Top module: `irq_flag_regs`

## Requirements
- R1: While reset is asserted, the status reads 0, the mask reads 0 and the interrupt line is low. The transmit threshold reads 1 and the receive threshold reads 32.
- R2: Word addresses are as follows: status 0 (read, write-one-to-clear), enable-set 1 (write only), enable-clear 2 (write only), mask 3 (read only), transmit threshold 4 and receive threshold 5 (both read/write). Addresses 1, 2, 6 and 7 read as 0. Reads are combinational from the current address.
- R3: Status bit 0 (receive overrun) and bit 6 (transmit underrun) are set at the clock edge that samples their event pulse. They then stay set until they are cleared.
- R4: A status write with a one at bit 0 or bit 6 clears that event bit at the next edge. If the bit's event pulse arrives in that same cycle, the bit stays set.
- R5: One cycle after the inputs are sampled, the level bits show the conditions against the thresholds held in that cycle. Bit 2 is transmit level < transmit threshold. Bit 3 is transmit level >= FIFO depth (63). Bit 4 is receive level >= receive threshold. Bit 5 is receive level >= FIFO depth. Writing ones to the status register does not change the level bits.
- R6: Writing ones to enable-set sets those mask bits. Writing ones to enable-clear clears them. All other mask bits keep their values.
- R7: Bits 1 and 7 and up of the status and mask registers always read 0.
- R8: Writes to the thresholds take effect at the next edge, and the thresholds read back the written low bits.
- R9: The interrupt line is high exactly when some bit is set in both the status register and the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| tx_level_i | input | LVL_W | Current transmit FIFO fill level |
| rx_level_i | input | LVL_W | Current receive FIFO fill level |
| rx_ovf_i | input | 1 | Receive overrun event pulse |
| tx_unf_i | input | 1 | Transmit underrun event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences place each FIFO level one below, at and above its threshold and at the full depth. This shows whether each watermark comparison is strict or inclusive, and whether the threshold is applied per direction. Event pulses are sent alone, followed by a clear, and also together with a clear in the same cycle. These cases separate sticky behaviour from level behaviour and show which side wins a collision. A seeded random run then mixes writes to all eight addresses, random levels, random pulses and threshold changes. A cycle model checks every read and the interrupt line on every cycle, so a swapped bit, a wrong mask update or an extra latency stage shows up.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   localparam int NUM_SRC   = 7;
   localparam int B_RX_OVF  = 0;
   localparam int B_TX_LOW  = 2;
   localparam int B_TX_FULL = 3;
   localparam int B_RX_WM   = 4;
   localparam int B_RX_FULL = 5;
   localparam int B_TX_UNF  = 6;

   localparam logic [NUM_SRC-1:0] EVENT_BITS = 7'b100_0001;
   localparam logic [NUM_SRC-1:0] LEVEL_BITS = 7'b011_1100;
   localparam logic [NUM_SRC-1:0] VALID_BITS = EVENT_BITS | LEVEL_BITS;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
   localparam logic [ADDR_W-1:0] A_ENSET = 3'd1;
   localparam logic [ADDR_W-1:0] A_ENCLR = 3'd2;
   localparam logic [ADDR_W-1:0] A_MASK  = 3'd3;
   localparam logic [ADDR_W-1:0] A_TXTH  = 3'd4;
   localparam logic [ADDR_W-1:0] A_RXTH  = 3'd5;

   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_cond_gen.sv
module irq_cond_gen
   import irq_flag_pkg::*;
#(
   parameter int LVL_W      = 7,
   parameter int FIFO_DEPTH = 63
) (
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] tx_thr_i,
   input  logic [LVL_W-1:0] rx_thr_i,
   input  logic             rx_ovf_i,
   input  logic             tx_unf_i,
   output src_vec_t         raw_o
);
   localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

   always_comb begin
      raw_o            = '0;
      raw_o[B_RX_OVF]  = rx_ovf_i;
      raw_o[B_TX_LOW]  = tx_level_i < tx_thr_i;
      raw_o[B_TX_FULL] = tx_level_i >= DEPTH_L;
      raw_o[B_RX_WM]   = rx_level_i >= rx_thr_i;
      raw_o[B_RX_FULL] = rx_level_i >= DEPTH_L;
      raw_o[B_TX_UNF]  = tx_unf_i;
   end
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
   import irq_flag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t raw_i,
   input  src_vec_t clr_i,
   output src_vec_t q_o
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (EVENT_BITS[i]) begin : g_evt
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= raw_i[i] | (bit_q & ~clr_i[i]);
         end
         assign q_o[i] = bit_q;

         // R3
         evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            raw_i[i] |=> q_o[i]);
         // R3
         evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
         // R4
         evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !raw_i[i]) |=> !q_o[i]);
      end else if (LEVEL_BITS[i]) begin : g_lvl
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= raw_i[i];
         end
         assign q_o[i] = bit_q;
         logic unused_clr;
         assign unused_clr = clr_i[i];
      end else begin : g_rsvd
         assign q_o[i] = 1'b0;
         logic unused_in;
         assign unused_in = raw_i[i] ^ clr_i[i];
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import irq_flag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set_we_i,
   input  logic     clr_we_i,
   input  src_vec_t bits_i,
   output src_vec_t mask_o
);
   src_vec_t mask_q;
   src_vec_t set_v;
   src_vec_t clr_v;

   assign set_v = set_we_i ? (bits_i & VALID_BITS) : '0;
   assign clr_v = clr_we_i ? bits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q | set_v) & ~clr_v;
   end
   assign mask_o = mask_q;

   // R6
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we_i |=> ((mask_o & $past(bits_i & VALID_BITS)) == $past(bits_i & VALID_BITS)));
   // R6
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((mask_o & $past(bits_i)) == '0));
   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we_i && !clr_we_i) |=> $stable(mask_o));
   // R7
   mask_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & ~VALID_BITS) == '0);
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
   import irq_flag_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int LVL_W      = 7,
   parameter int FIFO_DEPTH = 63,
   parameter int TX_THR_RST = 1,
   parameter int RX_THR_RST = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we_i,
   input  logic [2:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic [LVL_W-1:0]  tx_level_i,
   input  logic [LVL_W-1:0]  rx_level_i,
   input  logic              rx_ovf_i,
   input  logic              tx_unf_i,
   output logic              irq_o
);
   if (DATA_W < NUM_SRC || DATA_W < LVL_W) begin : g_bad_dw
      $error("DATA_W too narrow for status or threshold fields");
   end
   if (FIFO_DEPTH < 1 || FIFO_DEPTH >= (1 << LVL_W)) begin : g_bad_depth
      $error("FIFO_DEPTH must fit in LVL_W bits");
   end
   if (TX_THR_RST >= (1 << LVL_W) || RX_THR_RST >= (1 << LVL_W)) begin : g_bad_thr
      $error("threshold reset values must fit in LVL_W bits");
   end

   logic [LVL_W-1:0] tx_thr_q;
   logic [LVL_W-1:0] rx_thr_q;
   src_vec_t         raw;
   src_vec_t         st_q;
   src_vec_t         mask;
   src_vec_t         wbits;
   src_vec_t         st_clr;
   logic             unused_hi;

   assign wbits     = reg_wdata_i[NUM_SRC-1:0];
   assign unused_hi = ^reg_wdata_i;
   assign st_clr    = (reg_we_i && reg_addr_i == A_STAT) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr_q <= LVL_W'(TX_THR_RST);
         rx_thr_q <= LVL_W'(RX_THR_RST);
      end else if (reg_we_i) begin
         if (reg_addr_i == A_TXTH) tx_thr_q <= reg_wdata_i[LVL_W-1:0];
         if (reg_addr_i == A_RXTH) rx_thr_q <= reg_wdata_i[LVL_W-1:0];
      end
   end

   irq_cond_gen #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_cond (
      .tx_level_i (tx_level_i),
      .rx_level_i (rx_level_i),
      .tx_thr_i   (tx_thr_q),
      .rx_thr_i   (rx_thr_q),
      .rx_ovf_i   (rx_ovf_i),
      .tx_unf_i   (tx_unf_i),
      .raw_o      (raw)
   );

   irq_status_bits u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw),
      .clr_i (st_clr),
      .q_o   (st_q)
   );

   irq_mask_reg u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we_i (reg_we_i && reg_addr_i == A_ENSET),
      .clr_we_i (reg_we_i && reg_addr_i == A_ENCLR),
      .bits_i   (wbits),
      .mask_o   (mask)
   );

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_STAT:  reg_rdata_o = DATA_W'(st_q);
         A_MASK:  reg_rdata_o = DATA_W'(mask);
         A_TXTH:  reg_rdata_o = DATA_W'(tx_thr_q);
         A_RXTH:  reg_rdata_o = DATA_W'(rx_thr_q);
         default: reg_rdata_o = '0;
      endcase
   end

   assign irq_o = |(st_q & mask);

   // R9
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq_o);
   // R5
   tx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level_i < tx_thr_q) |=> st_q[B_TX_LOW]);
   // R5
   rx_wm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level_i < rx_thr_q) |=> !st_q[B_RX_WM]);
   // R8
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we_i |=> ($stable(tx_thr_q) && $stable(rx_thr_q)));
endmodule

// File: tb/irq_flag_regs_tb.sv
module irq_flag_regs_tb_top;
   localparam logic [6:0] EVT = 7'b100_0001;
   localparam logic [6:0] LVL = 7'b011_1100;
   localparam logic [6:0] VAL = 7'b111_1101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [6:0]  txl = '0;
   logic [6:0]  rxl = '0;
   logic        ovf = 1'b0;
   logic        unf = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   logic [6:0] m_st = '0, m_mask = '0, m_txt = 7'd1, m_rxt = 7'd32;

   always #5 clk = ~clk;

   irq_flag_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_level_i(txl),
      .rx_level_i(rxl), .rx_ovf_i(ovf), .tx_unf_i(unf), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] raw_of(input logic [6:0] t, input logic [6:0] r,
                                         input logic o, input logic u,
                                         input logic [6:0] tt, input logic [6:0] rt);
      logic [6:0] v = '0;
      v[0] = o;
      v[2] = t < tt;
      v[3] = t >= 7'd63;
      v[4] = r >= rt;
      v[5] = r >= 7'd63;
      v[6] = u;
      return v;
   endfunction

   function automatic logic [31:0] rd_exp(input logic [2:0] a);
      case (a)
         3'd0: return {25'd0, m_st};
         3'd3: return {25'd0, m_mask};
         3'd4: return {25'd0, m_txt};
         3'd5: return {25'd0, m_rxt};
         default: return 32'd0;
      endcase
   endfunction

   task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [6:0] t, input logic [6:0] r,
                       input logic o, input logic u, input string tag);
      logic [6:0] raw, clr;
      @(negedge clk);
      we = w; addr = a; wdata = d; txl = t; rxl = r; ovf = o; unf = u;
      raw = raw_of(t, r, o, u, m_txt, m_rxt);
      clr = (w && a == 3'd0) ? d[6:0] : 7'd0;
      m_st = (raw & LVL) | (EVT & (raw | (m_st & ~clr)));
      if (w) begin
         if (a == 3'd1) m_mask = m_mask | (d[6:0] & VAL);
         if (a == 3'd2) m_mask = m_mask & ~d[6:0];
         if (a == 3'd4) m_txt = d[6:0];
         if (a == 3'd5) m_rxt = d[6:0];
      end
      @(posedge clk);
      #1;
      chk({"R9 irq ", tag}, {31'd0, irq}, {31'd0, |(m_st & m_mask)});
      if (!w) chk({tag, " read"}, rdata, rd_exp(a));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      // R1 reset values, read combinationally while reset is held
      repeat (2) @(negedge clk);
      addr = 3'd0; #1 chk("R1 status", rdata, 32'd0);
      addr = 3'd3; #1 chk("R1 mask", rdata, 32'd0);
      addr = 3'd4; #1 chk("R1 tx thr", rdata, 32'd1);
      addr = 3'd5; #1 chk("R1 rx thr", rdata, 32'd32);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 level bits after reset: tx 0 < 1
      step(0, 3'd0, 0, 7'd0, 7'd0, 0, 0, "R5 tx empty");
      // R8 threshold write and readback
      step(1, 3'd4, 32'hFFFF_FF85, 7'd0, 7'd0, 0, 0, "R8 wr tx thr");
      step(0, 3'd4, 0, 7'd4, 7'd0, 0, 0, "R8 tx thr readback");
      step(0, 3'd0, 0, 7'd4, 7'd0, 0, 0, "R5 tx one below thr");
      step(0, 3'd0, 0, 7'd5, 7'd0, 0, 0, "R5 tx at thr");
      step(0, 3'd0, 0, 7'd63, 7'd31, 0, 0, "R5 tx full rx below");
      step(0, 3'd0, 0, 7'd6, 7'd32, 0, 0, "R5 rx at thr");
      step(0, 3'd0, 0, 7'd6, 7'd63, 0, 0, "R5 rx full");
      // R5 clearing a level bit has no effect while condition holds
      step(1, 3'd0, 32'h7F, 7'd6, 7'd63, 0, 0, "R5 w1c level");
      step(0, 3'd0, 0, 7'd6, 7'd63, 0, 0, "R5 level after w1c");
      // R3 sticky events
      step(0, 3'd0, 0, 7'd6, 7'd0, 1, 0, "R3 overrun set");
      step(0, 3'd0, 0, 7'd6, 7'd0, 0, 0, "R3 overrun held");
      step(0, 3'd0, 0, 7'd6, 7'd0, 0, 1, "R3 underrun set");
      // R4 clear, then collision
      step(1, 3'd0, 32'h01, 7'd6, 7'd0, 0, 0, "R4 clear overrun");
      step(0, 3'd0, 0, 7'd6, 7'd0, 0, 0, "R4 after clear");
      step(1, 3'd0, 32'h40, 7'd6, 7'd0, 0, 1, "R4 collide underrun");
      step(0, 3'd0, 0, 7'd6, 7'd0, 0, 0, "R4 event wins");
      // R6 / R7 mask handling
      step(1, 3'd1, 32'hFF, 7'd6, 7'd0, 0, 0, "R6 enable all");
      step(0, 3'd3, 0, 7'd6, 7'd0, 0, 0, "R7 mask reserved zero");
      step(0, 3'd1, 0, 7'd6, 7'd0, 0, 0, "R2 enset reads zero");
      step(0, 3'd2, 0, 7'd6, 7'd0, 0, 0, "R2 enclr reads zero");
      step(1, 3'd2, 32'h45, 7'd6, 7'd0, 0, 0, "R6 disable some");
      step(0, 3'd3, 0, 7'd6, 7'd0, 0, 0, "R6 mask after disable");
      step(1, 3'd0, 32'h41, 7'd6, 7'd0, 0, 0, "R9 clear events");
      step(0, 3'd6, 0, 7'd6, 7'd0, 0, 0, "R2 unused addr");

      // seeded random mix
      void'($urandom(32'd20240611));
      for (int n = 0; n < 600; n++) begin
         logic w;
         logic [2:0] a;
         logic [31:0] d;
         w = ($urandom % 3) == 0;
         a = 3'($urandom % 8);
         d = $urandom;
         if (a == 3'd4 || a == 3'd5) d = {$urandom, 6'(d)} & 32'hFFFF_FF3F;
         step(w, a, d, 7'($urandom % 64), 7'($urandom % 64),
              ($urandom % 5) == 0, ($urandom % 6) == 0, "R2 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule